// File: doc/BRIEF.md
# Cluster Cross-Core Semaphore Bank

This block holds the synchronisation counters for a compute cluster built from one master unit and two worker lanes. It has 16 event slots. Each slot has its own 4-bit counter for each worker lane. A set from the master is a broadcast: in one cycle it raises the slot's counter in both lanes. A set from a worker raises only that worker's own counter. A wait from the master is a reduce. It is held until both lanes have a pending count on the slot. It then completes with a single grant and takes one count from each lane in the same cycle. A wait from a worker takes one count from its own lane.

Requests arrive on two valid/ready ports, one for sets and one for waits. Each port carries an origin flag (master or worker), a core-select operand and an event operand. The set port never applies back-pressure. The wait port holds `wait_ready` low while the addressed counters cannot satisfy the request. The requester must then keep `wait_valid` and its operands steady until `wait_ready` is high on a clock edge, and that edge is the grant. `wait_ready` is combinational from the current counters and the wait operands. Counter updates take effect at the next rising edge.

Three error pulses report bad requests in the same cycle the request is presented:
- `err_event` for an event operand out of range.
- `err_core` for a bad core select from a worker.
- `err_overflow` when a counter wraps.

Top module: `xcore_sema_bank`

## Requirements
- R1: Event operands 0 to 15 address the 16 slots. A set or wait whose event operand is 16 or above pulses `err_event` in that cycle and changes no counter. Such a wait is accepted at once, with `wait_ready` high.
- R2: Each lane counter of each slot is 4 bits wide (0 to 15). An accepted set adds one and a granted wait subtracts one.
- R3: A set that finds a counter at 15 wraps that counter to 0 and pulses `err_overflow` in the same cycle as the set.
- R4: A set with `set_from_master`=1 increments the addressed slot's counters in both lanes at the same clock edge.
- R5: A wait with `wait_from_master`=1 has `wait_ready` high only when both lane counters of the slot are nonzero. On the grant edge both counters are decremented together.
- R6: For worker requests, core select 0 picks lane 0 and 1 picks lane 1. Any other value pulses `err_core`, changes no counter, and a wait with such a value is accepted at once. Master requests ignore the core select entirely.
- R7: A set with `set_from_master`=0 increments only the selected lane's counter for the slot.
- R8: A worker wait has `wait_ready` high when its own lane counter is nonzero, and that counter drops by one on the grant. While the counter is zero, `wait_ready` is low and `wait_stall` is high whenever `wait_valid` is high.
- R9: When a granted wait and an accepted set hit the same lane counter in one cycle, the counter keeps its value and no overflow is flagged. A wait sees the counter value from before that cycle's set, so a wait on a zero counter is not granted by a set in the same cycle.
- R10: A synchronous active-high `rst` clears every counter to 0, so no wait on a legal slot can be granted until a new set arrives.
- R11: `set_ready` is always high, and every valid set completes in the cycle it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| set_valid | input | 1 | Set request present |
| set_ready | output | 1 | Set accepted (always high) |
| set_from_master | input | 1 | 1: broadcast set from master, 0: worker set |
| set_core | input | SEL_W | Worker lane select for a set |
| set_evt | input | EVT_W | Event operand of the set |
| wait_valid | input | 1 | Wait request present |
| wait_ready | output | 1 | Wait can complete this cycle |
| wait_from_master | input | 1 | 1: reduce wait from master, 0: worker wait |
| wait_core | input | SEL_W | Worker lane select for a wait |
| wait_evt | input | EVT_W | Event operand of the wait |
| wait_stall | output | 1 | Valid wait is being held |
| err_event | output | 1 | Event operand out of range, this cycle |
| err_core | output | 1 | Worker core select out of range, this cycle |
| err_overflow | output | 1 | A counter wrapped from 15 to 0, this cycle |

## Verification
Master broadcasts are mixed with per-lane worker waits. This shows whether one set really reaches both lanes, and whether each lane drains on its own. Worker sets to a single lane, followed by master waits, show that the reduce holds until both lanes have signalled. They also show that a lone lane count is never taken. Runs of sets up to the wrap point, with and without a granted wait in the same cycle, separate a true wrap from the cancelling case. Out-of-range event and core operands are then checked by probing the slot those operands would alias to, so a design that truncates instead of rejecting is caught.

// File: rtl/xcore_sema_pkg.sv
package xcore_sema_pkg;
  localparam int unsigned LANES = 2;
  typedef logic [LANES-1:0] lane_mask_t;
endpackage

// File: rtl/xcore_sema_decode.sv
module xcore_sema_decode
  import xcore_sema_pkg::*;
#(
  parameter int unsigned NUM_EVENTS = 16,
  parameter int unsigned EVT_W      = 5,
  parameter int unsigned SEL_W      = 2,
  parameter int unsigned IDX_W      = 4
) (
  input  logic             from_master,
  input  logic [SEL_W-1:0] core_sel,
  input  logic [EVT_W-1:0] evt,
  output logic             bad_event,
  output logic             bad_core,
  output logic             legal,
  output lane_mask_t       lanes,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    bad_event = (int'(evt) >= NUM_EVENTS);
    bad_core  = !from_master && (int'(core_sel) >= LANES);
    legal     = !bad_event && !bad_core;
    idx       = IDX_W'(evt);
  end

  // Master requests cover every lane; worker requests pick one lane.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lanes[l] = from_master || (int'(core_sel) == l);
  end
endmodule

// File: rtl/xcore_sema_cell.sv
module xcore_sema_cell #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  // Simultaneous inc and dec cancel. Dec is only issued on nonzero counts.
  always_ff @(posedge clk) begin
    if (rst)               count <= '0;
    else if (inc && !dec)  count <= count + 1'b1;
    else if (dec && !inc)  count <= count - 1'b1;
  end

  assign wrap = inc && !dec && (&count);
endmodule

// File: rtl/xcore_sema_bank.sv
module xcore_sema_bank
  import xcore_sema_pkg::*;
#(
  parameter int unsigned NUM_EVENTS = 16,
  parameter int unsigned CNT_W      = 4,
  parameter int unsigned EVT_W      = 5,
  parameter int unsigned SEL_W      = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_valid,
  output logic             set_ready,
  input  logic             set_from_master,
  input  logic [SEL_W-1:0] set_core,
  input  logic [EVT_W-1:0] set_evt,
  input  logic             wait_valid,
  output logic             wait_ready,
  input  logic             wait_from_master,
  input  logic [SEL_W-1:0] wait_core,
  input  logic [EVT_W-1:0] wait_evt,
  output logic             wait_stall,
  output logic             err_event,
  output logic             err_core,
  output logic             err_overflow
);
  localparam int unsigned IDX_W  = (NUM_EVENTS > 1) ? $clog2(NUM_EVENTS) : 1;
  localparam int unsigned NCELLS = LANES * NUM_EVENTS;

  logic             s_bad_event, s_bad_core, s_legal;
  logic             w_bad_event, w_bad_core, w_legal;
  lane_mask_t       s_lanes, w_lanes, w_nonzero;
  logic [IDX_W-1:0] s_idx, w_idx;
  logic             s_fire, w_sat, w_grant;
  logic [CNT_W-1:0] cnt [LANES][NUM_EVENTS];
  logic [NCELLS-1:0] wrap_vec;

  xcore_sema_decode #(
    .NUM_EVENTS(NUM_EVENTS), .EVT_W(EVT_W), .SEL_W(SEL_W), .IDX_W(IDX_W)
  ) u_set_dec (
    .from_master(set_from_master), .core_sel(set_core), .evt(set_evt),
    .bad_event(s_bad_event), .bad_core(s_bad_core), .legal(s_legal),
    .lanes(s_lanes), .idx(s_idx)
  );

  xcore_sema_decode #(
    .NUM_EVENTS(NUM_EVENTS), .EVT_W(EVT_W), .SEL_W(SEL_W), .IDX_W(IDX_W)
  ) u_wait_dec (
    .from_master(wait_from_master), .core_sel(wait_core), .evt(wait_evt),
    .bad_event(w_bad_event), .bad_core(w_bad_core), .legal(w_legal),
    .lanes(w_lanes), .idx(w_idx)
  );

  assign s_fire = set_valid && s_legal;

  // Reduce: every lane named by the wait must hold a pending count.
  for (genvar l = 0; l < LANES; l++) begin : g_nz
    assign w_nonzero[l] = |cnt[l][w_idx];
  end
  assign w_sat   = &(~w_lanes | w_nonzero);
  assign w_grant = wait_valid && w_legal && w_sat;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar e = 0; e < NUM_EVENTS; e++) begin : g_evt
      logic hit_inc, hit_dec;
      assign hit_inc = s_fire  && s_lanes[l] && (int'(s_idx) == e);
      assign hit_dec = w_grant && w_lanes[l] && (int'(w_idx) == e);
      xcore_sema_cell #(.CNT_W(CNT_W)) u_cell (
        .clk(clk), .rst(rst), .inc(hit_inc), .dec(hit_dec),
        .count(cnt[l][e]), .wrap(wrap_vec[l*NUM_EVENTS+e])
      );
    end
  end

  assign set_ready    = 1'b1;
  assign wait_ready   = !w_legal || w_sat;
  assign wait_stall   = wait_valid && !wait_ready;
  assign err_event    = (set_valid && s_bad_event) || (wait_valid && w_bad_event);
  assign err_core     = (set_valid && s_bad_core)  || (wait_valid && w_bad_core);
  assign err_overflow = |wrap_vec;
endmodule

// File: rtl/xcore_sema_check.sv
module xcore_sema_check #(
  parameter int unsigned NUM_EVENTS = 16,
  parameter int unsigned EVT_W      = 5,
  parameter int unsigned SEL_W      = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             set_valid,
  input logic             set_from_master,
  input logic [SEL_W-1:0] set_core,
  input logic [EVT_W-1:0] set_evt,
  input logic             wait_valid,
  input logic             wait_ready,
  input logic             wait_from_master,
  input logic [SEL_W-1:0] wait_core,
  input logic [EVT_W-1:0] wait_evt,
  input logic             wait_stall,
  input logic             err_event,
  input logic             err_core,
  input logic             err_overflow
);
  logic w_ok;
  assign w_ok = (int'(wait_evt) < NUM_EVENTS) && (wait_from_master || int'(wait_core) < 2);

  assert_wrap_needs_set_R3: assert property (@(posedge clk) disable iff (rst)
    err_overflow |-> set_valid);

  assert_event_range_R1: assert property (@(posedge clk) disable iff (rst)
    err_event |-> ((set_valid && int'(set_evt) >= NUM_EVENTS) ||
                   (wait_valid && int'(wait_evt) >= NUM_EVENTS)));

  assert_core_range_R6: assert property (@(posedge clk) disable iff (rst)
    err_core |-> ((set_valid && !set_from_master && int'(set_core) > 1) ||
                  (wait_valid && !wait_from_master && int'(wait_core) > 1)));

  assert_bad_wait_no_stall_R1: assert property (@(posedge clk) disable iff (rst)
    (wait_valid && !w_ok) |-> (wait_ready && !wait_stall));

  assert_empty_after_reset_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && wait_valid && w_ok) |-> wait_stall);
endmodule

bind xcore_sema_bank xcore_sema_check #(
  .NUM_EVENTS(NUM_EVENTS), .EVT_W(EVT_W), .SEL_W(SEL_W)
) u_chk (
  .clk(clk), .rst(rst), .set_valid(set_valid), .set_from_master(set_from_master),
  .set_core(set_core), .set_evt(set_evt), .wait_valid(wait_valid),
  .wait_ready(wait_ready), .wait_from_master(wait_from_master),
  .wait_core(wait_core), .wait_evt(wait_evt), .wait_stall(wait_stall),
  .err_event(err_event), .err_core(err_core), .err_overflow(err_overflow)
);

// File: tb/xcore_sema_bank_test.sv
module xcore_sema_bank_test;
  logic       clk = 0;
  logic       rst = 1;
  logic       set_valid = 0, set_from_master = 0;
  logic [1:0] set_core = 0;
  logic [4:0] set_evt = 0;
  logic       wait_valid = 0, wait_from_master = 0;
  logic [1:0] wait_core = 0;
  logic [4:0] wait_evt = 0;
  logic       set_ready, wait_ready, wait_stall, err_event, err_core, err_overflow;

  int total = 0, bad = 0;
  int model [2][16];
  bit finished = 0;

  always #5 clk = ~clk;

  xcore_sema_bank uut (
    .clk(clk), .rst(rst), .set_valid(set_valid), .set_ready(set_ready),
    .set_from_master(set_from_master), .set_core(set_core), .set_evt(set_evt),
    .wait_valid(wait_valid), .wait_ready(wait_ready),
    .wait_from_master(wait_from_master), .wait_core(wait_core), .wait_evt(wait_evt),
    .wait_stall(wait_stall), .err_event(err_event), .err_core(err_core),
    .err_overflow(err_overflow)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int l = 0; l < 2; l++) for (int e = 0; e < 16; e++) model[l][e] = 0;
  endtask

  // One clock: drive, compare against reference, advance reference.
  task automatic step(input bit sv, input bit sm, input int sc, input int se,
                      input bit wv, input bit wm, input int wc, input int we,
                      input string tag);
    bit s_bev, s_bc, s_ok, w_bev, w_bc, w_ops, sat, grant, e_rdy, e_ev, e_co, e_ov;
    @(negedge clk);
    set_valid = sv; set_from_master = sm; set_core = 2'(sc); set_evt = 5'(se);
    wait_valid = wv; wait_from_master = wm; wait_core = 2'(wc); wait_evt = 5'(we);
    #1;
    s_bev = se >= 16; s_bc = !sm && sc > 1; s_ok = sv && !s_bev && !s_bc;
    w_bev = we >= 16; w_bc = !wm && wc > 1; w_ops = !w_bev && !w_bc;
    sat = 0;
    if (w_ops) sat = wm ? (model[0][we] > 0 && model[1][we] > 0) : (model[wc][we] > 0);
    e_rdy = !w_ops || sat;
    grant = wv && w_ops && sat;
    e_ev = (sv && s_bev) || (wv && w_bev);
    e_co = (sv && s_bc) || (wv && w_bc);
    e_ov = 0;
    for (int l = 0; l < 2; l++) begin
      bit inc_l, dec_l;
      inc_l = s_ok && (sm || sc == l);
      dec_l = grant && (wm || wc == l) && we == se;
      if (inc_l && !dec_l && model[l][se] == 15) e_ov = 1;
    end
    if (wv) chk(wait_ready == e_rdy, tag, "wait_ready", wait_ready, e_rdy);
    chk(wait_stall == (wv && !e_rdy), tag, "wait_stall", wait_stall, wv && !e_rdy);
    chk(err_event == e_ev, tag, "err_event", err_event, e_ev);
    chk(err_core == e_co, tag, "err_core", err_core, e_co);
    chk(err_overflow == e_ov, tag, "err_overflow", err_overflow, e_ov);
    if (sv) chk(set_ready == 1'b1, "R11", "set_ready", set_ready, 1);
    @(posedge clk);
    for (int l = 0; l < 2; l++) begin
      if (grant && (wm || wc == l)) model[l][we]--;
      if (s_ok && (sm || sc == l)) model[l][se] = (model[l][se] + 1) % 16;
    end
  endtask

  task automatic wset(input int lane, input int ev, input string tag);
    step(1, 0, lane, ev, 0, 0, 0, 0, tag);
  endtask
  task automatic mset(input int ev, input int core, input string tag);
    step(1, 1, core, ev, 0, 0, 0, 0, tag);
  endtask
  task automatic wwait(input int lane, input int ev, input string tag);
    step(0, 0, 0, 0, 1, 0, lane, ev, tag);
  endtask
  task automatic mwait(input int ev, input string tag);
    step(0, 0, 0, 0, 1, 1, 0, ev, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; set_valid = 0; wait_valid = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 0;
    clear_model();
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog timeout");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    clear_model();
    do_reset();
    // R10: counters empty after reset
    mwait(0, "R10");
    wwait(0, 15, "R10");
    // R4, R6: master broadcast ignores core select value 3
    mset(3, 3, "R4");
    mset(3, 0, "R4");
    wwait(0, 3, "R8"); wwait(0, 3, "R8"); wwait(0, 3, "R8");
    wwait(1, 3, "R4"); wwait(1, 3, "R4"); wwait(1, 3, "R4");
    // R5, R7: reduce waits for both lanes
    wset(0, 5, "R7");
    mwait(5, "R5");
    wwait(1, 5, "R7");
    wset(1, 5, "R7");
    mwait(5, "R5");
    mwait(5, "R5");
    wwait(0, 5, "R5");
    // R2, R3: sixteen sets wrap the counter to 0 with an overflow pulse
    for (int i = 0; i < 16; i++) wset(0, 7, "R3");
    wwait(0, 7, "R3");
    mset(8, 1, "R2"); mset(8, 1, "R2");
    mwait(8, "R2"); mwait(8, "R2"); mwait(8, "R2");
    // R1: out-of-range events alias nothing
    wset(0, 16, "R1");
    mset(20, 0, "R1");
    wwait(0, 0, "R1");
    wwait(1, 4, "R1");
    mwait(17, "R1");
    wset(1, 31, "R1");
    wwait(1, 15, "R1");
    // R6: bad worker core select
    step(1, 0, 2, 1, 0, 0, 0, 0, "R6");
    step(1, 0, 3, 1, 1, 0, 2, 1, "R6");
    wwait(0, 1, "R6"); wwait(1, 1, "R6");
    // R9: wait on zero counter not granted by same-cycle set
    step(1, 0, 1, 4, 1, 0, 1, 4, "R9");
    wwait(1, 4, "R9"); wwait(1, 4, "R9");
    // R9: same-cycle set and grant on a full counter cancel
    for (int i = 0; i < 15; i++) wset(0, 9, "R9");
    step(1, 0, 0, 9, 1, 0, 0, 9, "R9");
    step(1, 1, 0, 9, 1, 0, 0, 9, "R9");
    wset(0, 9, "R9");
    // R10: reset mid-run clears pending counts
    mset(2, 0, "R10"); mset(2, 0, "R10");
    do_reset();
    wwait(0, 2, "R10"); mwait(2, "R10");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R11");
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule